// File: doc/BRIEF.md
# Dual-Port Audio Interrupt and Reset Controller

This block sits beside a pair of audio ports, A and B, each with a playback (output) and a capture (input) direction. Each direction raises a one-cycle data-request pulse. The block latches every pulse into a shared pending register. Two enable masks qualify the pending bits, and both must agree before a source counts. The qualified result drives one registered interrupt line towards the CPU.

The same register bus also reaches the reset and clock controls for the audio interface. There is a global soft reset, an interrupt-logic reset and one reset per port, all active low, plus a clock-run bit per port. A read-only capacity register reports the size code of each port's FIFO, which is fixed at build time.

Accesses whose address falls outside the block's window, or that are not word aligned, have no effect on a write and return zero on a read.

Top module: `aud_irq_ctrl`

## Requirements
- R1: A pulse on `evt_i[i]` sets pending bit 4*i of the status register (offset 0x00): bit 0 is port A output, bit 4 is port A input, bit 8 is port B output and bit 12 is port B input. The bit stays set after the pulse ends.
- R2: `irq_o` goes high one cycle after a pending bit exists whose bit is also set in both mask registers (offsets 0x04 and 0x08, same layout as the status register). If the bit is clear in either mask, `irq_o` stays low.
- R3: A write to the status register clears every pending bit written as 0 and leaves bits written as 1 unchanged. Writing zero clears all sources.
- R4: An event that arrives in the same cycle as a write clearing its bit takes priority, so the bit stays set.
- R5: While bit 4 of the soft-reset register (offset 0x0C) is 0, all pending bits are cleared and new events are not latched. Once the bit returns to 1, events latch again.
- R6: In the soft-reset register, bit 0 is the global reset and drives `sys_rst_n_o`. Bits 8 and 12 drive `port_rst_n_o[0]` and `port_rst_n_o[1]`. A port is held in reset while its own bit or the global bit is 0. While the global bit is 0, pending bits are also cleared.
- R7: In the clock register (offset 0x10), bit 0 drives `clk_run_o[0]` for port A and bit 4 drives `clk_run_o[1]` for port B.
- R8: The capacity register (offset 0x14) reads the port A code at bits 2:0 and the port B code at bits 10:8. Writes to it have no effect.
- R9: A write outside the window BASE..BASE+0x14, or to an address that is not word aligned, changes no register. A read from such an address returns zero.
- R10: After reset the status, both masks and the clock register read 0, the soft-reset register reads 0x0011, `irq_o` is low, `sys_rst_n_o` is high and both port resets are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 4 | Data-request pulses; index 2*p is port p output, 2*p+1 is port p input |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | CPU interrupt, registered |
| sys_rst_n_o | output | 1 | Global soft reset, active low |
| port_rst_n_o | output | 2 | Per-port reset, active low |
| clk_run_o | output | 2 | Per-port clock run enable |

## Verification
The bench keeps two ports and the window base of 0x200. It sets the two capacity codes to 2 and 5, which differ from each other and from zero, so a swapped or misplaced field shows up on a read. With four sources spread across bits 0 to 12, every status position, every mask combination and both port reset bits can be reached. Unaligned and out-of-window accesses are also placed close to the window edge.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_STAT  = 3'd1,
        SEL_MASK0 = 3'd2,
        SEL_MASK1 = 3'd3,
        SEL_SWRST = 3'd4,
        SEL_CLK   = 3'd5,
        SEL_CAP   = 3'd6
    } reg_sel_e;

    localparam int OFS_STAT  = 'h00;
    localparam int OFS_MASK0 = 'h04;
    localparam int OFS_MASK1 = 'h08;
    localparam int OFS_SWRST = 'h0C;
    localparam int OFS_CLK   = 'h10;
    localparam int OFS_CAP   = 'h14;
    localparam int OFS_LAST  = OFS_CAP;

    // spacing of per-source and per-port fields on the bus
    localparam int SRC_STRIDE  = 4;
    localparam int PORT_STRIDE = 8;
    localparam int CAP_W       = 3;

endpackage

// File: rtl/aud_irq_dec.sv
module aud_irq_dec
    import aud_irq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BASE   = 'h200
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE + OFS_LAST);

    logic [ADDR_W-1:0] ofs;

    always_comb begin
        ofs   = addr_i - LO;
        sel_o = SEL_NONE;
        if (addr_i >= LO && addr_i <= HI && addr_i[1:0] == 2'b00) begin
            case (int'(ofs))
                OFS_STAT:  sel_o = SEL_STAT;
                OFS_MASK0: sel_o = SEL_MASK0;
                OFS_MASK1: sel_o = SEL_MASK1;
                OFS_SWRST: sel_o = SEL_SWRST;
                OFS_CLK:   sel_o = SEL_CLK;
                OFS_CAP:   sel_o = SEL_CAP;
                default:   sel_o = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/aud_irq_cfg.sv
module aud_irq_cfg
    import aud_irq_pkg::*;
#(
    parameter int NPORT  = 2,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  reg_sel_e             sel_i,
    input  logic                 wr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [2*NPORT-1:0]   mask0_o,
    output logic [2*NPORT-1:0]   mask1_o,
    output logic                 glob_o,
    output logic                 irst_o,
    output logic [NPORT-1:0]     prst_o,
    output logic [NPORT-1:0]     clk_o
);
    localparam int NSRC = 2 * NPORT;

    typedef struct packed {
        logic [NSRC-1:0]  mask0;
        logic [NSRC-1:0]  mask1;
        logic             glob;
        logic             irst;
        logic [NPORT-1:0] prst;
        logic [NPORT-1:0] clk;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [NSRC-1:0]  wr_src;
    logic [NPORT-1:0] wr_prst, wr_clk;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign wr_src[i] = wdata_i[i*SRC_STRIDE];
    end
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign wr_prst[p] = wdata_i[PORT_STRIDE + p*SRC_STRIDE];
        assign wr_clk[p]  = wdata_i[p*SRC_STRIDE];
    end

    logic unused_wd;
    assign unused_wd = ^wdata_i;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            case (sel_i)
                SEL_MASK0: cfg_d.mask0 = wr_src;
                SEL_MASK1: cfg_d.mask1 = wr_src;
                SEL_SWRST: begin
                    cfg_d.glob = wdata_i[0];
                    cfg_d.irst = wdata_i[SRC_STRIDE];
                    cfg_d.prst = wr_prst;
                end
                SEL_CLK:   cfg_d.clk = wr_clk;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            cfg_q.glob <= 1'b1;
            cfg_q.irst <= 1'b1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mask0_o = cfg_q.mask0;
    assign mask1_o = cfg_q.mask1;
    assign glob_o  = cfg_q.glob;
    assign irst_o  = cfg_q.irst;
    assign prst_o  = cfg_q.prst;
    assign clk_o   = cfg_q.clk;

    // R9: a write that decodes to no register leaves the configuration untouched
    assert_no_stray_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_NONE) |=> (cfg_q == $past(cfg_q)));
endmodule

// File: rtl/aud_irq_stat.sv
module aud_irq_stat #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic            clr_en_i,
    input  logic [NSRC-1:0] keep_i,
    input  logic            hold_i,
    input  logic [NSRC-1:0] mask0_i,
    input  logic [NSRC-1:0] mask1_i,
    output logic [NSRC-1:0] pend_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic            irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_i) begin
            st_d.pend = '0;
        end else begin
            st_d.pend = (clr_en_i ? (st_q.pend & keep_i) : st_q.pend) | evt_i;
        end
        st_d.irq = |(st_q.pend & mask0_i & mask1_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign irq_o  = st_q.irq;

    // R2: a doubly enabled pending source raises the line on the next cycle
    assert_irq_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_o & mask0_i & mask1_i)) |=> irq_o);
    // R2: nothing doubly enabled keeps the line low on the next cycle
    assert_irq_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend_o & mask0_i & mask1_i)) |=> !irq_o);
    // R4: an arriving event is always latched unless the hold is active
    assert_evt_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && evt_i != '0) |=> ((pend_o & $past(evt_i)) == $past(evt_i)));
    // R5: the hold empties the pending register
    assert_hold_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (pend_o == '0));
endmodule

// File: rtl/aud_irq_ctrl.sv
module aud_irq_ctrl
    import aud_irq_pkg::*;
#(
    parameter int         NPORT  = 2,
    parameter int         ADDR_W = 12,
    parameter int         DATA_W = 32,
    parameter int         BASE   = 'h200,
    parameter logic [2:0] CAP_A  = 3'd0,
    parameter logic [2:0] CAP_B  = 3'd0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*NPORT-1:0]  evt_i,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq_o,
    output logic                sys_rst_n_o,
    output logic [NPORT-1:0]    port_rst_n_o,
    output logic [NPORT-1:0]    clk_run_o
);
    localparam int NSRC = 2 * NPORT;

    reg_sel_e         sel;
    logic [NSRC-1:0]  mask0, mask1, pend, keep;
    logic             glob, irst;
    logic [NPORT-1:0] prst, clkr;
    logic [2:0]       cap [NPORT];

    aud_irq_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .addr_i (bus_addr),
        .sel_o  (sel)
    );

    aud_irq_cfg #(.NPORT(NPORT), .DATA_W(DATA_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (sel),
        .wr_i    (bus_wr),
        .wdata_i (bus_wdata),
        .mask0_o (mask0),
        .mask1_o (mask1),
        .glob_o  (glob),
        .irst_o  (irst),
        .prst_o  (prst),
        .clk_o   (clkr)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_keep
        assign keep[i] = bus_wdata[i*SRC_STRIDE];
    end
    for (genvar p = 0; p < NPORT; p++) begin : g_cap
        assign cap[p] = (p == 0) ? CAP_A : ((p == 1) ? CAP_B : 3'd0);
    end

    aud_irq_stat #(.NSRC(NSRC)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .clr_en_i (bus_wr && sel == SEL_STAT),
        .keep_i   (keep),
        .hold_i   (!irst || !glob),
        .mask0_i  (mask0),
        .mask1_i  (mask1),
        .pend_o   (pend),
        .irq_o    (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_STAT:  for (int i = 0; i < NSRC; i++) bus_rdata[i*SRC_STRIDE] = pend[i];
            SEL_MASK0: for (int i = 0; i < NSRC; i++) bus_rdata[i*SRC_STRIDE] = mask0[i];
            SEL_MASK1: for (int i = 0; i < NSRC; i++) bus_rdata[i*SRC_STRIDE] = mask1[i];
            SEL_SWRST: begin
                bus_rdata[0]          = glob;
                bus_rdata[SRC_STRIDE] = irst;
                for (int p = 0; p < NPORT; p++)
                    bus_rdata[PORT_STRIDE + p*SRC_STRIDE] = prst[p];
            end
            SEL_CLK:   for (int p = 0; p < NPORT; p++) bus_rdata[p*SRC_STRIDE] = clkr[p];
            SEL_CAP:   for (int p = 0; p < NPORT; p++) bus_rdata[p*PORT_STRIDE +: CAP_W] = cap[p];
            default:   bus_rdata = '0;
        endcase
    end

    assign sys_rst_n_o  = glob;
    assign port_rst_n_o = prst & {NPORT{glob}};
    assign clk_run_o    = clkr;

    // R6: global reset low forces every port into reset
    assert_glob_ports_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n_o |-> (port_rst_n_o == '0));
    // R8: writes to the capacity register leave its contents unchanged
    assert_cap_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_CAP) |-> (bus_rdata[2:0] == CAP_A));
endmodule

// File: tb/aud_irq_ctrl_tb.sv
module aud_irq_ctrl_tb;
    localparam int BASE = 'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  evt = '0;
    logic [11:0] addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, sysn;
    logic [1:0]  prstn, clkrun;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    aud_irq_ctrl #(.BASE(BASE), .CAP_A(3'd2), .CAP_B(3'd5)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt),
        .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_o(irq), .sys_rst_n_o(sysn), .port_rst_n_o(prstn), .clk_run_o(clkrun)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int ofs, input logic [31:0] d);
        @(negedge clk);
        addr = 12'(BASE + ofs); wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input int ofs, output logic [31:0] d);
        @(negedge clk);
        addr = 12'(BASE + ofs);
        #1 d = rdata;
    endtask

    task automatic pulse(input logic [3:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd_reg('h00, d); check("R10 status", d, 0);
        rd_reg('h04, d); check("R10 mask0", d, 0);
        rd_reg('h08, d); check("R10 mask1", d, 0);
        rd_reg('h0C, d); check("R10 swrst", d, 32'h0011);
        rd_reg('h10, d); check("R10 clk", d, 0);
        check("R10 irq/sys/ports", {irq, sysn, prstn, clkrun}, 32'b010000);
    endtask

    task automatic t_latch;
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            pulse(4'(1 << i));
            rd_reg('h00, d); check("R1 latch position", d, 32'(1) << (4*i));
            wr_reg('h00, 0);
        end
        rd_reg('h00, d); check("R3 all cleared", d, 0);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        wr_reg('h04, 32'h1111);
        wr_reg('h08, 32'h0001);
        @(negedge clk); evt = 4'b0100;
        @(negedge clk); evt = '0;
        check("R2 not both masks", {31'b0, irq}, 0);
        @(negedge clk);
        check("R2 masked source quiet", {31'b0, irq}, 0);
        @(negedge clk); evt = 4'b0001;
        @(negedge clk); evt = '0;       // pending set at last edge
        check("R2 not yet", {31'b0, irq}, 0);
        @(negedge clk);
        check("R2 irq raised", {31'b0, irq}, 1);
        wr_reg('h00, 32'h0100);       // clear bit0 keep bit8
        rd_reg('h00, d); check("R3 selective clear", d, 32'h0100);
        @(negedge clk);
        check("R2 irq dropped", {31'b0, irq}, 0);
        wr_reg('h00, 0);
        wr_reg('h04, 0); wr_reg('h08, 0);
    endtask

    task automatic t_race;
        logic [31:0] d;
        pulse(4'b1000);
        @(negedge clk);
        addr = 12'(BASE); wdata = 0; wr = 1'b1; evt = 4'b1000;
        @(negedge clk);
        wr = 1'b0; evt = '0;
        rd_reg('h00, d); check("R4 event beats clear", d, 32'h1000);
        wr_reg('h00, 0);
    endtask

    task automatic t_irst;
        logic [31:0] d;
        pulse(4'b0010);
        wr_reg('h0C, 32'h0001);
        rd_reg('h00, d); check("R5 cleared by IR low", d, 0);
        pulse(4'b0010);
        rd_reg('h00, d); check("R5 ignored while low", d, 0);
        wr_reg('h0C, 32'h0011);
        pulse(4'b0010);
        rd_reg('h00, d); check("R5 latching again", d, 32'h0010);
        wr_reg('h00, 0);
    endtask

    task automatic t_ports;
        logic [31:0] d;
        wr_reg('h0C, 32'h1111);
        check("R6 ports released", {sysn, prstn}, 3'b111);
        wr_reg('h0C, 32'h0111);
        check("R6 port B only", {sysn, prstn}, 3'b101);
        pulse(4'b0001);
        wr_reg('h0C, 32'h1110);
        check("R6 global low", {sysn, prstn}, 3'b000);
        rd_reg('h00, d); check("R6 global clears status", d, 0);
        wr_reg('h0C, 32'h0011);
    endtask

    task automatic t_clk;
        wr_reg('h10, 32'h0010);
        check("R7 port B clock", {30'b0, clkrun}, 2'b10);
        wr_reg('h10, 32'h0001);
        check("R7 port A clock", {30'b0, clkrun}, 2'b01);
        wr_reg('h10, 0);
    endtask

    task automatic t_cap;
        logic [31:0] d;
        rd_reg('h14, d); check("R8 capacity", d, 32'h0502);
        wr_reg('h14, 32'hFFFF_FFFF);
        rd_reg('h14, d); check("R8 write ignored", d, 32'h0502);
    endtask

    task automatic t_window;
        logic [31:0] d;
        wr_reg('h18, 32'h1111);           // just past the window
        wr_reg('h05, 32'h1111);           // unaligned inside
        wr_reg(-'h200 + 'h4, 32'h1111);   // far below
        rd_reg('h04, d); check("R9 mask unchanged", d, 0);
        rd_reg('h18, d); check("R9 outside reads zero", d, 0);
        rd_reg('h15, d); check("R9 unaligned reads zero", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_latch;
        t_irq;
        t_race;
        t_irst;
        t_ports;
        t_clk;
        t_cap;
        t_window;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule